// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-programmed watchdog. The input clock is slowed in two stages before it reaches the counter. The first stage is a programmable divider from 1 to 256. The second is a fixed divider chosen from 16, 32, 64 or 128. Each output tick of this chain steps a 16-bit live counter down by one. When the counter is at zero, the next tick reloads it from a reload register and fires the expiry actions. There are two actions, each with its own enable: a one-cycle interrupt pulse, and a reset request that stays high for a fixed number of clocks.

Software services the watchdog by writing a fresh value into the live count register before the count runs out. To stop the watchdog, software clears both the run bit and the reset-action bit. The bus is a plain synchronous port. A write is taken on the clock edge while the write strobe is high. Read data is a combinational function of the address.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0xFF33 and both the reload register and the live count read 0x8000. In the control value, run is 1, reset-action is 1, interrupt-action is 0, the divider select is 3 and the prescale field is 0xFF.
- R2: The register map is as follows. Address 0 is control, address 1 is reload and address 2 is live count. Address 3 reads 0 and ignores writes. The control register is laid out as bit 0 run, bit 1 reset-action enable, bit 2 interrupt-action enable, bits 5:4 divider select and bits 15:8 prescale value P. Bits 3, 7 and 6 read 0. Control and reload read back what was written.
- R3: A write to the live count takes effect on that edge and wins over a tick on the same edge. Rewriting it before it expires prevents any expiry.
- R4: While run is set, a tick occurs every (P+1)·(16·2^S) clocks, where S is the divider select. The first tick comes a full period after run is set.
- R5: Each tick lowers a nonzero count by one. While run is clear, the count does not change unless it is written.
- R6: A tick that finds the count at zero loads the reload value.
- R7: On that reloading tick, the interrupt output is high for exactly one clock if interrupt-action is enabled. Otherwise it stays low.
- R8: On that reloading tick, the reset request goes high for exactly 128 clocks if reset-action is enabled.
- R9: Clearing run and reset-action together freezes the counter and drops any reset request one clock later. No reset request follows after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_o | output | 1 | One-clock expiry interrupt |
| rst_req_o | output | 1 | Stretched expiry reset request |

## Verification
Every register write is visible on the read port in the clock after its write edge. Ticks land exactly (P+1)·(16·2^S) edges after run is set. The interrupt and the reset request both rise on the edge of the reloading tick. The reset request falls 128 edges later, or one edge after reset-action is cleared. The bench keeps a behavioural model that uses the same edge counts and drives inputs on falling edges. It compares the interrupt, the reset request and the read data 1 ns after every rising edge. Directed checks count falling edges from the end of the enabling write to land on the exact tick and expiry cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_NONE   = 2'd3
   } wd_reg_e;

   localparam int RUN_BIT   = 0;
   localparam int RSTEN_BIT = 1;
   localparam int IRQEN_BIT = 2;
   localparam int SEL_LSB   = 4;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
   parameter int PRE_W         = 8,
   parameter int SEL_W         = 2,
   parameter int DIV_LOG2_BASE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre_lim,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = DIV_LOG2_BASE + (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_lim;
   logic             pre_wrap;

   always_comb begin
      div_lim  = DIV_W'((1 << (DIV_LOG2_BASE + int'(sel))) - 1);
      pre_wrap = run && (pre_cnt == pre_lim);
      tick     = pre_wrap && (div_cnt == div_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (!run) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else begin
         pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
         if (pre_wrap)
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
   parameter int CNT_W       = 16,
   parameter int RESET_COUNT = 32'h8000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   assign expire = tick && !load && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(RESET_COUNT);
      else if (load)
         cnt <= load_val;
      else if (tick)
         cnt <= expire ? reload_val : cnt - 1'b1;
   end
endmodule

// File: rtl/wdog_pulse_hold.sv
module wdog_pulse_hold #(
   parameter int HOLD = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic arm,
   output logic active
);
   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("wdog_pulse_hold: HOLD must be at least 1");
      end

      if (HOLD == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= allow && arm;
         end
         assign active = q;
      end else begin : g_stretch
         localparam int HW = $clog2(HOLD + 1);
         logic [HW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left <= '0;
            else if (!allow)
               left <= '0;
            else if (arm)
               left <= HW'(HOLD);
            else if (left != '0)
               left <= left - 1'b1;
         end
         assign active = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int CNT_W         = 16,
   parameter int PRE_W         = 8,
   parameter int SEL_W         = 2,
   parameter int DIV_LOG2_BASE = 4,
   parameter int RST_HOLD      = 128,
   parameter int RESET_COUNT   = 32'h8000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [wdog_pkg::ADDR_W-1:0]  bus_addr,
   input  logic                         bus_we,
   input  logic [CNT_W-1:0]             bus_wdata,
   output logic [CNT_W-1:0]             bus_rdata,
   output logic                         irq_o,
   output logic                         rst_req_o
);
   import wdog_pkg::*;

   localparam int PRE_LSB = CNT_W - PRE_W;
   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   generate
      if (SEL_MSB >= PRE_LSB) begin : g_bad_layout
         $error("wdog_timer: control fields overlap, widen CNT_W");
      end
      if (RESET_COUNT >= (1 << CNT_W)) begin : g_bad_reset
         $error("wdog_timer: RESET_COUNT does not fit CNT_W");
      end
   endgenerate

   logic             run_q, rsten_q, irqen_q;
   logic [SEL_W-1:0] sel_q;
   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt;
   logic             wr_ctrl, wr_reload, wr_count;
   logic             tick, expire, irq_q;

   assign wr_ctrl   = bus_we && (bus_addr == REG_CTRL);
   assign wr_reload = bus_we && (bus_addr == REG_RELOAD);
   assign wr_count  = bus_we && (bus_addr == REG_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b1;
         rsten_q  <= 1'b1;
         irqen_q  <= 1'b0;
         sel_q    <= '1;
         pre_q    <= '1;
         reload_q <= CNT_W'(RESET_COUNT);
      end else begin
         if (wr_ctrl) begin
            run_q   <= bus_wdata[RUN_BIT];
            rsten_q <= bus_wdata[RSTEN_BIT];
            irqen_q <= bus_wdata[IRQEN_BIT];
            sel_q   <= bus_wdata[SEL_MSB:SEL_LSB];
            pre_q   <= bus_wdata[CNT_W-1:PRE_LSB];
         end
         if (wr_reload)
            reload_q <= bus_wdata;
      end
   end

   wdog_tick_gen #(
      .PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_LOG2_BASE(DIV_LOG2_BASE)
   ) tick_i (
      .clk(clk), .rst_n(rst_n), .run(run_q),
      .pre_lim(pre_q), .sel(sel_q), .tick(tick)
   );

   wdog_down_cnt #(
      .CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)
   ) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_count),
      .load_val(bus_wdata), .reload_val(reload_q),
      .cnt(cnt), .expire(expire)
   );

   wdog_pulse_hold #(
      .HOLD(RST_HOLD)
   ) hold_i (
      .clk(clk), .rst_n(rst_n), .allow(rsten_q),
      .arm(expire), .active(rst_req_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= expire && irqen_q;
   end
   assign irq_o = irq_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: begin
            bus_rdata[RUN_BIT]           = run_q;
            bus_rdata[RSTEN_BIT]         = rsten_q;
            bus_rdata[IRQEN_BIT]         = irqen_q;
            bus_rdata[SEL_MSB:SEL_LSB]   = sel_q;
            bus_rdata[CNT_W-1:PRE_LSB]   = pre_q;
         end
         REG_RELOAD: bus_rdata = reload_q;
         REG_COUNT:  bus_rdata = cnt;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int CNT_W    = 16,
   parameter int RST_HOLD = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_we,
   input logic [CNT_W-1:0] bus_wdata,
   input logic             run,
   input logic             rsten,
   input logic             irqen,
   input logic [CNT_W-1:0] cnt,
   input logic             irq,
   input logic             rst_req
);
   logic wr_cnt;
   int   hi_len;

   assign wr_cnt = bus_we && (bus_addr == wdog_pkg::REG_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_len <= 0;
      else
         hi_len <= rst_req ? hi_len + 1 : 0;
   end

   always @(posedge clk) begin
      if (rst_n)
         assert_hold_len_R8: assert (hi_len <= RST_HOLD)
            else $error("reset request held longer than %0d clocks", RST_HOLD);
   end

   assert_cnt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> cnt == $past(bus_wdata));

   assert_frozen_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt));

   assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irqen));

   assert_rst_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(rsten));

   assert_rst_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsten |=> !rst_req);
endmodule

bind wdog_timer wdog_timer_chk #(
   .CNT_W(CNT_W), .RST_HOLD(RST_HOLD)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .run(run_q), .rsten(rsten_q), .irqen(irqen_q),
   .cnt(cnt), .irq(irq_o), .rst_req(rst_req_o)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd2;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o, rst_req_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   wdog_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   // behavioural reference model
   logic [15:0] m_ctrl, m_reload, m_cnt;
   int          m_phase, m_hold;
   bit          m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 16'hFF33; m_reload = 16'h8000; m_cnt = 16'h8000;
         m_phase = 0; m_hold = 0; m_irq = 0;
      end else begin
         int  period;
         bit  tk, exp_now;
         period = (int'(m_ctrl[15:8]) + 1) * (16 << m_ctrl[5:4]);
         tk = 0;
         exp_now = 0;
         if (!m_ctrl[0]) m_phase = 0;
         else begin
            m_phase++;
            if (m_phase == period) begin tk = 1; m_phase = 0; end
         end
         if (bus_we && bus_addr == 2'd2) m_cnt = bus_wdata;
         else if (tk) begin
            if (m_cnt == 0) begin m_cnt = m_reload; exp_now = 1; end
            else m_cnt = m_cnt - 1;
         end
         m_irq = exp_now && m_ctrl[2];
         if (!m_ctrl[1]) m_hold = 0;
         else if (exp_now) m_hold = 128;
         else if (m_hold > 0) m_hold--;
         if (bus_we && bus_addr == 2'd1) m_reload = bus_wdata;
         if (bus_we && bus_addr == 2'd0) m_ctrl = bus_wdata & 16'hFF37;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp_v, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [15:0] exp_rd;
         case (bus_addr)
            2'd0: exp_rd = m_ctrl;
            2'd1: exp_rd = m_reload;
            2'd2: exp_rd = m_cnt;
            default: exp_rd = 16'h0;
         endcase
         check(irq_o == m_irq, "R7 irq", int'(irq_o), int'(m_irq));
         check(rst_req_o == (m_hold != 0), "R8 rst_req", int'(rst_req_o), int'(m_hold != 0));
         check(bus_rdata == exp_rd, (bus_addr == 2'd2) ? "R5 count" : "R2 readback",
               int'(bus_rdata), int'(exp_rd));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 2'd2;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, input logic [15:0] exp_v, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(bus_rdata == exp_v, tag, int'(bus_rdata), int'(exp_v));
   endtask

   task automatic peek_cnt(input logic [15:0] exp_v, input string tag);
      #1;
      check(bus_rdata == exp_v, tag, int'(bus_rdata), int'(exp_v));
   endtask

   task automatic finish_run;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] frozen;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, 16'hFF33, "R1 ctrl reset");
      rd(2'd1, 16'h8000, "R1 reload reset");
      rd(2'd2, 16'h8000, "R1 count reset");

      // R4/R5/R6/R7: period 16, interrupt only
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd5);
      wr(2'd2, 16'd3);
      wr(2'd0, 16'h0005);
      idle(15); peek_cnt(16'd3, "R4 no tick before full period");
      idle(1);  peek_cnt(16'd2, "R4 first tick / R5 decrement");
      idle(48); peek_cnt(16'd5, "R6 reload on expiry");
      check(irq_o == 1'b1, "R7 irq on expiry", int'(irq_o), 1);
      check(rst_req_o == 1'b0, "R8 no reset when disabled", int'(rst_req_o), 0);
      idle(1);
      check(irq_o == 1'b0, "R7 irq one cycle", int'(irq_o), 0);
      wr(2'd2, 16'd9); peek_cnt(16'd9, "R3 count write immediate");
      idle(200);

      // R8: period 64, reset only
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd2);
      wr(2'd2, 16'd1);
      wr(2'd0, 16'h0113);
      idle(128);
      check(rst_req_o == 1'b1, "R8 reset rises", int'(rst_req_o), 1);
      check(irq_o == 1'b0, "R7 irq masked", int'(irq_o), 0);
      idle(127);
      check(rst_req_o == 1'b1, "R8 reset still held", int'(rst_req_o), 1);
      idle(1);
      check(rst_req_o == 1'b0, "R8 reset after 128 clocks", int'(rst_req_o), 0);

      // R3 keep-alive
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd2);
      wr(2'd2, 16'd2);
      wr(2'd0, 16'h0007);
      for (int i = 0; i < 10; i++) begin
         idle(30);
         check(irq_o == 1'b0 && rst_req_o == 1'b0, "R3 keep-alive no expiry",
               int'({irq_o, rst_req_o}), 0);
         wr(2'd2, 16'd2);
      end

      // R9 stop during a reset request
      idle(60);
      check(rst_req_o == 1'b1, "R9 expiry before stop", int'(rst_req_o), 1);
      wr(2'd0, 16'h0000);
      idle(1);
      check(rst_req_o == 1'b0, "R9 reset dropped", int'(rst_req_o), 0);
      #1 frozen = bus_rdata;
      idle(100);
      peek_cnt(frozen, "R9 counter frozen");
      check(rst_req_o == 1'b0, "R9 no later reset", int'(rst_req_o), 0);

      // R4/R6 divide-by-128 select
      wr(2'd1, 16'd7);
      wr(2'd2, 16'd0);
      wr(2'd0, 16'h0035);
      idle(127); peek_cnt(16'd0, "R4 select 3 no early tick");
      idle(1);   peek_cnt(16'd7, "R6 reload at 128 clocks");
      check(irq_o == 1'b1, "R7 irq select 3", int'(irq_o), 1);

      // R2 map
      wr(2'd3, 16'hABCD);
      rd(2'd3, 16'h0000, "R2 address 3 reads zero");
      rd(2'd1, 16'd7, "R2 reload readback");
      rd(2'd0, 16'h0035, "R2 ctrl readback");
      wr(2'd0, 16'hFFFF);
      rd(2'd0, 16'hFF37, "R2 reserved bits zero");
      wr(2'd0, 16'h0000);
      idle(4);
      finish_run();
   end
endmodule